// File: doc/BRIEF.md
# Interrupt Capture and Mask Bank

This block collects up to 32 interrupt sources into one request line. Each source owns a pending flag, which latches a single-cycle hardware event, and a mask flag, which decides whether that pending flag may reach the request output. The request output is high whenever at least one source is both pending and unmasked.

Software never writes either flag directly. It issues commands through four write-only addresses: one sets pending flags, one clears pending flags, one sets mask flags, and one clears mask flags. In every command, a 1 in a bit position acts on that source and a 0 leaves it unchanged. Two read-only views return the current pending and mask words. Bit i refers to the same source in all six addresses. Pending flags show the raw captured state whether or not the source is unmasked, so software can poll them with the request disabled.

Top module: `irqb_bank`

## Requirements
- R1: After a synchronous active-low reset, every pending flag is 0, every mask flag is 0, and `irq_o` is 0.
- R2: A one-cycle pulse on `evt_i[i]` sets pending flag i at the next clock edge. The flag stays set after the pulse ends.
- R3: A write to address 2 (pending-set) sets every pending flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: A write to address 3 (pending-clear) clears every pending flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: A write to address 4 (mask-set) sets the selected mask flags, and a write to address 5 (mask-clear) clears them. Data bits of 0 have no effect. Mask flags change only through these two addresses.
- R6: `irq_o` is 1 exactly when some source i has both pending flag i and mask flag i equal to 1.
- R7: Reading address 0 returns the pending flags in bits [NSRC-1:0], whatever the mask flags hold. Reading address 1 returns the mask flags.
- R8: If an event on source i and a pending-clear write with bit i set arrive in the same cycle, pending flag i ends up 1.
- R9: Reading address 2, 3, 4, 5, 6 or 7 returns 0. A write to address 0, 1, 6 or 7 changes no flag.
- R10: Read bits at and above NSRC are always 0. Write data bits at and above NSRC are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NSRC | Single-cycle event pulses, one per source, synchronous to clk |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_addr_i | input | 3 | Write address (0..7) |
| wr_data_i | input | 32 | Write data; bit i selects source i |
| rd_addr_i | input | 3 | Read address (0..7) |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Request: OR over all pending-and-unmasked sources |

## Verification
The assertions assume that event inputs are already synchronous to `clk` and are held for only one cycle per occurrence. They also assume that the write port carries at most one command per cycle, so the mask-set and mask-clear commands never meet on the same edge. The stimulus drives every input on the falling edge and never keeps an event high for more than one cycle. The one deliberate collision is an event that lands on the same edge as a pending-clear write, which is how the set-over-clear rule is exercised.

// File: rtl/irqb_pkg.sv
// Package: shared constants and the address map of the interrupt bank.
// Assumes a 32-bit register data path and eight word addresses.
package irqb_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    // Address map; the command addresses are write-only, the views read-only
    typedef enum logic [ADDR_W-1:0] {
        VIEW_PEND    = 3'd0,
        VIEW_MASK    = 3'd1,
        CMD_PEND_SET = 3'd2,
        CMD_PEND_CLR = 3'd3,
        CMD_MASK_SET = 3'd4,
        CMD_MASK_CLR = 3'd5,
        SLOT_SPARE6  = 3'd6,
        SLOT_SPARE7  = 3'd7
    } irqb_addr_e;
endpackage

// File: rtl/irqb_cmd_decode.sv
// Command decoder: turns one register write into four per-source command masks.
// Assumes one write per cycle; writes to views or spare slots yield no command.
module irqb_cmd_decode
    import irqb_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [NSRC-1:0]     pend_set_o,
    output logic [NSRC-1:0]     pend_clr_o,
    output logic [NSRC-1:0]     mask_set_o,
    output logic [NSRC-1:0]     mask_clr_o
);
    logic [NSRC-1:0] data_lo;

    // Keep only the bit positions that map to a source
    always_comb data_lo = wr_data_i[NSRC-1:0];

    // Route the write data to the one command it addresses
    always_comb begin
        pend_set_o = '0;
        pend_clr_o = '0;
        mask_set_o = '0;
        mask_clr_o = '0;
        if (wr_en_i) begin
            case (irqb_addr_e'(wr_addr_i))
                CMD_PEND_SET: pend_set_o = data_lo;
                CMD_PEND_CLR: pend_clr_o = data_lo;
                CMD_MASK_SET: mask_set_o = data_lo;
                CMD_MASK_CLR: mask_clr_o = data_lo;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/irqb_bit_cell.sv
// One source: pending flag (set wins over clear) and mask flag (clear wins).
// Assumes evt_i is a synchronous single-cycle pulse.
module irqb_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic pend_set_i,
    input  logic pend_clr_i,
    input  logic mask_set_i,
    input  logic mask_clr_i,
    output logic pend_o,
    output logic mask_o
);
    logic pend_q;
    logic mask_q;

    // Pending flag: event or set command beats a clear command
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_q <= 1'b0;
        else if (evt_i || pend_set_i)    pend_q <= 1'b1;
        else if (pend_clr_i)             pend_q <= 1'b0;
    end

    // Mask flag: clear command beats a set command
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= 1'b0;
        else if (mask_clr_i)  mask_q <= 1'b0;
        else if (mask_set_i)  mask_q <= 1'b1;
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R2 / R8: an event is never lost, even against a clear
    assert_event_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pend_q);

    // R4: a clear with no competing set empties the flag
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr_i && !pend_set_i && !evt_i) |=> !pend_q);

    // R5: mask moves only on its own commands
    assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_set_i && !mask_clr_i) |=> $stable(mask_q));

    // R1: first cycle out of reset shows both flags low
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pend_q && !mask_q));
endmodule

// File: rtl/irqb_rd_mux.sv
// Read mux: returns the pending or mask view, zero for every other address.
// Assumes reads are combinational and have no side effects.
module irqb_rd_mux
    import irqb_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic [NSRC-1:0]     pend_i,
    input  logic [NSRC-1:0]     mask_i,
    output logic [DATA_W-1:0]   rd_data_o
);
    // Select a view and zero-fill the bits above the source count
    always_comb begin
        rd_data_o = '0;
        case (irqb_addr_e'(rd_addr_i))
            VIEW_PEND: rd_data_o[NSRC-1:0] = pend_i;
            VIEW_MASK: rd_data_o[NSRC-1:0] = mask_i;
            default:   ;
        endcase
    end
endmodule

// File: rtl/irqb_req_tree.sv
// Request reduction: ORs the per-source pending-and-unmasked terms.
// Assumes both input words come straight from registers.
module irqb_req_tree #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] mask_i,
    output logic            req_o
);
    logic [NSRC-1:0] live;

    // Per-source gating, then a single wide OR
    always_comb begin
        live  = pend_i & mask_i;
        req_o = |live;
    end
endmodule

// File: rtl/irqb_bank.sv
// Top: interrupt capture and mask bank with NSRC sources and one request line.
// Assumes events are synchronous one-cycle pulses and writes are one per cycle.
module irqb_bank
    import irqb_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     evt_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                irq_o
);
    localparam int MAX_SRC = DATA_W;

    logic [NSRC-1:0] pend_set;
    logic [NSRC-1:0] pend_clr;
    logic [NSRC-1:0] mask_set;
    logic [NSRC-1:0] mask_clr;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;

    // Parameter range guard at elaboration
    initial begin
        assert_nsrc_range_R10: assert (NSRC >= 1 && NSRC <= MAX_SRC)
            else $error("NSRC out of range");
    end

    irqb_cmd_decode #(.NSRC(NSRC)) u_dec (
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .pend_set_o (pend_set),
        .pend_clr_o (pend_clr),
        .mask_set_o (mask_set),
        .mask_clr_o (mask_clr)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_cell
        irqb_bit_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[g]),
            .pend_set_i (pend_set[g]),
            .pend_clr_i (pend_clr[g]),
            .mask_set_i (mask_set[g]),
            .mask_clr_i (mask_clr[g]),
            .pend_o     (pend_q[g]),
            .mask_o     (mask_q[g])
        );
    end

    irqb_rd_mux #(.NSRC(NSRC)) u_rd (
        .rd_addr_i (rd_addr_i),
        .pend_i    (pend_q),
        .mask_i    (mask_q),
        .rd_data_o (rd_data_o)
    );

    irqb_req_tree #(.NSRC(NSRC)) u_req (
        .pend_i (pend_q),
        .mask_i (mask_q),
        .req_o  (irq_o)
    );

    // R6: a request implies at least one unmasked source
    assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q != '0));

    // R6: a request implies at least one pending source
    assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q != '0));

    // R9: write to a read-only view leaves the mask word unchanged
    assert_view_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == VIEW_PEND || wr_addr_i == VIEW_MASK)) |=> $stable(mask_q));
endmodule

// File: tb/sim_irqb_bank.sv
// Directed bench for irqb_bank: one task per scenario, each self-checking.
module sim_irqb_bank;
    localparam int NSRC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] evt = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqb_bank #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write command; returns after the capturing edge, at a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, d); check("R1 pending after reset", d, 32'h0);
        rd(3'd1, d); check("R1 mask after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_event;
        logic [31:0] d;
        @(negedge clk); evt = 8'h08;
        @(negedge clk); evt = '0;
        rd(3'd0, d); check("R2 event captured", d, 32'h08);
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); check("R2 flag sticky", d, 32'h08);
        check("R7 pending visible while masked, irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_pend_set;
        logic [31:0] d;
        wr(3'd2, 32'h31);
        rd(3'd0, d); check("R3 pending-set ORs bits", d, 32'h39);
    endtask

    task automatic t_pend_clr;
        logic [31:0] d;
        wr(3'd3, 32'h09);
        rd(3'd0, d); check("R4 pending-clear drops bits", d, 32'h30);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(3'd4, 32'h90);
        rd(3'd1, d); check("R5 mask-set", d, 32'h90);
        check("R6 irq on pending and unmasked", {31'b0, irq}, 32'h1);
        wr(3'd5, 32'h10);
        rd(3'd1, d); check("R5 mask-clear leaves others", d, 32'h80);
        check("R6 irq low when no overlap", {31'b0, irq}, 32'h0);
        rd(3'd0, d); check("R7 pending unaffected by mask", d, 32'h30);
    endtask

    task automatic t_irq_path;
        wr(3'd2, 32'h80);
        check("R6 irq rises via bit 7", {31'b0, irq}, 32'h1);
        wr(3'd3, 32'h80);
        check("R6 irq falls after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] d;
        @(negedge clk);
        evt = 8'h20; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h30;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        rd(3'd0, d); check("R8 event beats clear", d, 32'h20);
    endtask

    task automatic t_inert;
        logic [31:0] d;
        for (int a = 2; a < 8; a++) begin
            rd(a[2:0], d); check("R9 non-view read is zero", d, 32'h0);
        end
        wr(3'd0, 32'hFF); wr(3'd1, 32'hFF); wr(3'd6, 32'hFF); wr(3'd7, 32'hFF);
        rd(3'd0, d); check("R9 pending after inert writes", d, 32'h20);
        rd(3'd1, d); check("R9 mask after inert writes", d, 32'h80);
    endtask

    task automatic t_width;
        logic [31:0] d;
        wr(3'd2, 32'hFFFF_FF00);
        rd(3'd0, d); check("R10 upper write bits ignored", d, 32'h20);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R10 upper read bits zero", d, 32'hFF);
        check("R6 irq with bit 7 pending and unmasked", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event();
        t_pend_set();
        t_pend_clr();
        t_mask();
        t_irq_path();
        t_race();
        t_inert();
        t_width();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule